// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher with Wildcard Fields

This block watches a clock's hours, minutes and seconds bytes and compares them against three programmed alarm bytes. The comparison is made only once per clock update, in the cycle where the update-done strobe is high. At that point the time bytes already hold their new values. If every alarm byte that takes part in the comparison equals its time byte, a sticky alarm flag is set. The interrupt request output is the flag gated by an alarm enable.

Any alarm byte can be taken out of the comparison by writing ones into its two top bits. Such a byte is a wildcard. Making the hours byte a wildcard turns a daily alarm into an hourly one. Making hours and minutes wildcards gives an alarm every minute, and making all three wildcards gives an alarm on every update, once per second. The flag is cleared by software through a one-cycle clear strobe.

The time counter and the register file that hold these bytes are outside this block. All pins are plain level or strobe signals. The block has no streaming data path, so no valid/ready handshake applies.

Top module: `tmatch_alarm`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `alarm_flag` and `alarm_irq` are 0.
- R2: When `upd_done` is 1 on a rising clock edge and every non-wildcard alarm byte equals its time byte, `alarm_flag` is 1 from the next cycle on.
- R3: An alarm byte whose bits 7:6 are 2'b11 is a wildcard and always counts as matching, whatever its bits 5:0 hold. Any other alarm byte is compared with its time byte over all 8 bits.
- R4: The wildcard patterns select the alarm rate. With no wildcard, all three bytes must match (daily). With only hours wildcarded, minutes and seconds must match (hourly). With hours and minutes wildcarded, only seconds must match (each minute). With all three wildcarded, every update fires (each second).
- R5: On an edge where `upd_done` is 0, matching bytes leave `alarm_flag` unchanged.
- R6: Once set, `alarm_flag` stays 1 until a clear. A further match while it is set keeps it at 1.
- R7: A 1 on `flag_clr` at a rising edge makes `alarm_flag` 0 in the next cycle. The exception is an edge that also carries a qualifying match (R2): that match wins, and the flag is 1.
- R8: `alarm_irq` equals `alarm_flag` AND `alarm_en` in every cycle. `alarm_en` never changes `alarm_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_done | input | 1 | One-cycle strobe marking the end of a time update |
| time_hrs | input | 8 | Current hours byte |
| time_min | input | 8 | Current minutes byte |
| time_sec | input | 8 | Current seconds byte |
| alm_hrs | input | 8 | Alarm hours byte (wildcard when bits 7:6 = 11) |
| alm_min | input | 8 | Alarm minutes byte (wildcard when bits 7:6 = 11) |
| alm_sec | input | 8 | Alarm seconds byte (wildcard when bits 7:6 = 11) |
| alarm_en | input | 1 | Lets the flag drive the interrupt request |
| flag_clr | input | 1 | One-cycle strobe that clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm event flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The bench targets the following corner cases:

- **Wildcard detection.** Alarm bytes with only one of the top two bits set must still be compared. A design that tested just bit 7 would fire on a mismatch. Alarm bytes whose top bits are 11 but whose low bits differ from the time must still fire. A design that compared those bits would stay silent.
- **Strobe gating.** Matching bytes held without `upd_done` must not set the flag. A design that compared continuously would raise it early.
- **Clear racing a match.** A clear in the same cycle as a qualifying match must leave the flag set. Letting the clear win would lose an event.
- **Enable toggling.** Toggling the enable while the flag is set must only gate the request and never change the flag.

// File: rtl/tmatch_alarm_pkg.sv
package tmatch_alarm_pkg;
  parameter int unsigned BYTE_W   = 8;
  parameter int unsigned N_FIELDS = 3;
  parameter int unsigned WILD_W   = 2;

  typedef logic [BYTE_W-1:0] tbyte_t;

  typedef enum logic [1:0] {
    FLD_SEC = 2'd0,
    FLD_MIN = 2'd1,
    FLD_HRS = 2'd2
  } field_e;
endpackage

// File: rtl/tmatch_field_cmp.sv
module tmatch_field_cmp #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WILD_W = 2
) (
  input  logic [BYTE_W-1:0] cur_byte,
  input  logic [BYTE_W-1:0] alm_byte,
  output logic              is_wild,
  output logic              hit
);
  localparam int unsigned TOP = BYTE_W - 1;
  localparam int unsigned LOW = BYTE_W - WILD_W;

  always_comb begin
    is_wild = &alm_byte[TOP:LOW];
    hit     = is_wild | (cur_byte == alm_byte);
  end
endmodule

// File: rtl/tmatch_flag_reg.sv
module tmatch_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic enable,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end

  always_comb irq = flag & enable;
endmodule

// File: rtl/tmatch_alarm.sv
module tmatch_alarm
  import tmatch_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_done,
  input  logic [7:0] time_hrs,
  input  logic [7:0] time_min,
  input  logic [7:0] time_sec,
  input  logic [7:0] alm_hrs,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_sec,
  input  logic       alarm_en,
  input  logic       flag_clr,
  output logic       alarm_flag,
  output logic       alarm_irq
);
  tbyte_t               cur_v [N_FIELDS];
  tbyte_t               alm_v [N_FIELDS];
  logic  [N_FIELDS-1:0] wild_v;
  logic  [N_FIELDS-1:0] hit_v;
  logic                 all_hit;
  logic                 set_evt;

  always_comb begin
    cur_v[FLD_SEC] = time_sec;
    cur_v[FLD_MIN] = time_min;
    cur_v[FLD_HRS] = time_hrs;
    alm_v[FLD_SEC] = alm_sec;
    alm_v[FLD_MIN] = alm_min;
    alm_v[FLD_HRS] = alm_hrs;
  end

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    tmatch_field_cmp #(
      .BYTE_W(BYTE_W),
      .WILD_W(WILD_W)
    ) i_cmp (
      .cur_byte(cur_v[g]),
      .alm_byte(alm_v[g]),
      .is_wild (wild_v[g]),
      .hit     (hit_v[g])
    );
  end

  // wild_v is kept for visibility of which fields were excluded
  logic unused_wild;
  always_comb unused_wild = ^wild_v;

  always_comb begin
    all_hit = &hit_v;
    set_evt = upd_done & all_hit;
  end

  tmatch_flag_reg i_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(set_evt),
    .clr_evt(flag_clr),
    .enable (alarm_en),
    .flag   (alarm_flag),
    .irq    (alarm_irq)
  );
endmodule

// File: rtl/tmatch_alarm_chk.sv
module tmatch_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_done,
  input logic [7:0] time_hrs,
  input logic [7:0] time_min,
  input logic [7:0] time_sec,
  input logic [7:0] alm_hrs,
  input logic [7:0] alm_min,
  input logic [7:0] alm_sec,
  input logic       alarm_en,
  input logic       flag_clr,
  input logic       alarm_flag,
  input logic       alarm_irq
);
  logic all_wild;
  logic exact_all;
  always_comb begin
    all_wild  = (alm_hrs[7:6] == 2'b11) && (alm_min[7:6] == 2'b11) && (alm_sec[7:6] == 2'b11);
    exact_all = (alm_hrs == time_hrs) && (alm_min == time_min) && (alm_sec == time_sec);
  end

  assert_exact_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && exact_all) |=> alarm_flag);

  assert_all_wild_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && all_wild) |=> alarm_flag);

  assert_set_needs_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !upd_done) |=> !alarm_flag);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !flag_clr) |=> alarm_flag);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !upd_done) |=> !alarm_flag);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq == (alarm_flag && alarm_en));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R1: assert (!alarm_irq);
    end
  end
endmodule

bind tmatch_alarm tmatch_alarm_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_done  (upd_done),
  .time_hrs  (time_hrs),
  .time_min  (time_min),
  .time_sec  (time_sec),
  .alm_hrs   (alm_hrs),
  .alm_min   (alm_min),
  .alm_sec   (alm_sec),
  .alarm_en  (alarm_en),
  .flag_clr  (flag_clr),
  .alarm_flag(alarm_flag),
  .alarm_irq (alarm_irq)
);

// File: tb/test_tmatch_alarm.sv
`timescale 1ns/1ps
module test_tmatch_alarm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_done = 1'b0;
  logic [7:0] time_hrs = '0, time_min = '0, time_sec = '0;
  logic [7:0] alm_hrs = '0, alm_min = '0, alm_sec = '0;
  logic       alarm_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       alarm_flag, alarm_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic model_flag = 1'b0;

  always #10 clk = ~clk;

  tmatch_alarm i_tmatch_alarm (
    .clk(clk), .rst_n(rst_n), .upd_done(upd_done),
    .time_hrs(time_hrs), .time_min(time_min), .time_sec(time_sec),
    .alm_hrs(alm_hrs), .alm_min(alm_min), .alm_sec(alm_sec),
    .alarm_en(alarm_en), .flag_clr(flag_clr),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  function automatic logic byte_ok(input logic [7:0] t, input logic [7:0] a);
    return (a[7] && a[6]) ? 1'b1 : (t == a);
  endfunction

  function automatic logic next_flag(input logic cur);
    logic m;
    m = upd_done && byte_ok(time_hrs, alm_hrs) && byte_ok(time_min, alm_min)
        && byte_ok(time_sec, alm_sec);
    if (m) return 1'b1;
    if (flag_clr) return 1'b0;
    return cur;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive values at negedge, clock once, check at the following negedge
  task automatic step(input string req, input logic ud, input logic clr, input logic en,
                      input logic [7:0] th, input logic [7:0] tm, input logic [7:0] ts,
                      input logic [7:0] ah, input logic [7:0] am, input logic [7:0] as_);
    upd_done = ud; flag_clr = clr; alarm_en = en;
    time_hrs = th; time_min = tm; time_sec = ts;
    alm_hrs = ah; alm_min = am; alm_sec = as_;
    model_flag = next_flag(model_flag);
    @(posedge clk);
    @(negedge clk);
    check(req, alarm_flag, model_flag);
    check({req, "/R8"}, alarm_irq, model_flag & en);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 flag in reset", alarm_flag, 1'b0);
    check("R1 irq in reset", alarm_irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", alarm_flag, 1'b0);

    // R5: match without strobe
    step("R5 no strobe", 0, 0, 1, 8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56);
    // R2 exact daily match
    step("R2 daily match", 1, 0, 1, 8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56);
    // R8 enable toggles do not touch flag
    step("R8 enable off", 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01);
    // R6 sticky with new match
    step("R6 rematch while set", 1, 0, 1, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01);
    // R7 clear together with match: match wins
    step("R7 clear vs match", 1, 1, 1, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02);
    // R7 plain clear
    step("R7 clear", 0, 1, 1, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02);
    // R3: single top bit set is not a wildcard
    step("R3 0x80 not wild", 1, 0, 1, 8'h05, 8'h10, 8'h20, 8'h85, 8'h10, 8'h20);
    step("R3 0x40 not wild", 1, 0, 1, 8'h05, 8'h10, 8'h20, 8'h45, 8'h10, 8'h20);
    // R3 wildcard with arbitrary low bits
    step("R3 wild low bits", 1, 0, 1, 8'h05, 8'h10, 8'h20, 8'hE7, 8'h10, 8'h20);
    step("R7 clear 2", 0, 1, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    // R4 hourly: minute mismatch then match
    step("R4 hourly miss", 1, 0, 1, 8'h09, 8'h11, 8'h30, 8'hC0, 8'h12, 8'h30);
    step("R4 hourly hit", 1, 0, 1, 8'h09, 8'h12, 8'h30, 8'hC0, 8'h12, 8'h30);
    step("R7 clear 3", 0, 1, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    // R4 per minute and per second
    step("R4 minute hit", 1, 0, 1, 8'h21, 8'h45, 8'h07, 8'hFF, 8'hC3, 8'h07);
    step("R7 clear 4", 0, 1, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R4 second hit", 1, 0, 1, 8'h13, 8'h59, 8'h42, 8'hC1, 8'hD2, 8'hFC);
    step("R7 clear 5", 0, 1, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R2 daily miss", 1, 0, 1, 8'h13, 8'h59, 8'h42, 8'h13, 8'h59, 8'h43);

    // constrained random: alarm bytes are equal, wildcard or random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] t[3];
      logic [7:0] a[3];
      for (int k = 0; k < 3; k++) begin
        int unsigned sel;
        t[k] = 8'($urandom_range(0, 89));
        sel = $urandom_range(0, 9);
        if (sel < 5)      a[k] = t[k];
        else if (sel < 8) a[k] = 8'hC0 | 8'($urandom_range(0, 63));
        else              a[k] = 8'($urandom);
      end
      step("R2/R3/R5/R6/R7 random", ($urandom_range(0, 2) == 0),
           ($urandom_range(0, 4) == 0), ($urandom_range(0, 1) == 1),
           t[2], t[1], t[0], a[2], a[1], a[0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule